// File: doc/BRIEF.md
# Local Interrupt Acknowledge Logic

This block keeps the per-vector bookkeeping of a processor-local interrupt controller. Incoming requests set a bit in a 256-entry pending vector. When the core asks for an interrupt, the block picks the highest pending vector. The pick is gated by a software-enable bit and by a task-priority threshold. An accepted vector moves from the pending set to the in-service set. An end-of-interrupt strobe retires the highest vector that is in service.

The block also drives a level interrupt line to the core. This line is high when the best pending vector outranks both the current in-service work and the task priority by priority class. A second output tells the legacy 8259-style interrupt path whether it may deliver to this core. That depends on the controller identifier, a global enable, and the delivery mode held in the local vector entry for the first local interrupt pin.

An INIT input returns the architectural registers to their power-on-after-INIT values, apart from the global enable. Register writes use a two-bit selector. Acknowledge results come back one cycle after the request.

Top module: `lirq_ack_core`

## Requirements
- R1: After reset the pending and in-service sets are empty, task priority is 0, the spurious register is 0x0FF (enable bit 8 clear), the local pin entry is 0x00700, and the global enable is 1.
- R2: A cycle with `pend_valid` high sets bit `pend_vec` of the pending set, even when an acknowledge clears that same bit in that cycle.
- R3: An acknowledge request yields `ack_valid` high for exactly the following cycle, with `ack_none` and `ack_vec` valid in that cycle; `ack_valid` is low otherwise.
- R4: While bit 8 of the spurious register is clear, an acknowledge returns `ack_none`=1 and leaves the pending set unchanged.
- R5: An acknowledge considers the highest-numbered pending vector; with nothing pending it returns `ack_none`=1.
- R6: If task priority is nonzero and the selected vector is less than or equal to it, the acknowledge returns `ack_none`=0 with `ack_vec` equal to bits 7:0 of the spurious register, and the pending set is unchanged.
- R7: Otherwise the acknowledge returns `ack_none`=0 with the selected vector, clears it from the pending set and sets it in the in-service set.
- R8: An end-of-interrupt strobe clears the highest-numbered in-service bit; with the in-service set empty it changes nothing.
- R9: `irq_out` is high exactly when something is pending and the priority class (bits 7:4) of the highest pending vector exceeds both the class of the highest in-service vector (0 when none) and the class of the task priority.
- R10: INIT clears the pending and in-service sets and task priority, sets the spurious register to 0x0FF and the local pin entry to masked (0x10000), and leaves the global enable alone.
- R11: `pic_accept` is high exactly when `self_id` is 0 and either the global enable is 0, or the local pin entry has mask bit 16 clear and delivery mode bits 10:8 equal to 7.
- R12: With `wr_en` high, `wr_sel` 0 writes task priority from `wr_data[7:0]`, 1 writes the spurious register from `wr_data[8:0]`, 2 writes the local pin entry from `wr_data[16:0]`, and 3 writes the global enable from `wr_data[0]`. INIT in the same cycle overrides the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_evt | input | 1 | INIT event strobe |
| self_id | input | 8 | Identifier of this controller |
| pend_valid | input | 1 | Set-pending strobe |
| pend_vec | input | 8 | Vector to mark pending |
| ack_req | input | 1 | Acknowledge request from the core |
| eoi_strobe | input | 1 | End-of-interrupt strobe |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | Register select (see R12) |
| wr_data | input | 17 | Register write data |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_none | output | 1 | No interrupt to deliver |
| ack_vec | output | 8 | Delivered vector or spurious vector |
| irq_out | output | 1 | Interrupt request level to the core |
| pic_accept | output | 1 | Legacy controller may deliver to this core |

## Verification
The bench sweeps every vector through set, acknowledge and retire. A wrong priority encoder or a class compare taken from the wrong bits shows up there as a wrong returned vector or a wrong `irq_out` level. Two threshold cases get targeted checks: a vector equal to the task priority, which a design comparing with strict less-than would deliver, and one just above it, which must be delivered. A spurious return is repeated to show that the request survives it, so a design that consumes the request is caught. End-of-interrupt is checked with two vectors in service, so retiring the lowest leaves `irq_out` low where it should rise. After INIT, a low-class request is raised to catch a task priority or in-service bit that survived. The legacy-acceptance table is swept over identifier, enable, mask and all eight delivery modes.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

    typedef enum logic [1:0] {
        SEL_TPR   = 2'd0,
        SEL_SPUR  = 2'd1,
        SEL_LINT0 = 2'd2,
        SEL_GEN   = 2'd3
    } lirq_sel_e;

    localparam int          LVT_W        = 17;
    localparam int          LVT_MASK_BIT = 16;
    localparam int          LVT_MODE_LO  = 8;
    localparam int          LVT_MODE_W   = 3;
    localparam logic [2:0]  MODE_EXTINT  = 3'd7;
    localparam logic [LVT_W-1:0] LINT0_RST  = 17'h00700;
    localparam logic [LVT_W-1:0] LVT_MASKED = 17'h10000;
    localparam int          CLS_W        = 4;

endpackage

// File: rtl/lirq_hi_find.sv
module lirq_hi_find #(
    parameter int W  = 256,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // Highest set bit wins because later iterations overwrite earlier ones.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) begin
                any_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/lirq_prio_cmp.sv
module lirq_prio_cmp #(
    parameter int CW = 4
) (
    input  logic          irr_any_i,
    input  logic [CW-1:0] irr_cls_i,
    input  logic          isr_any_i,
    input  logic [CW-1:0] isr_cls_i,
    input  logic [CW-1:0] tpr_cls_i,
    output logic          irq_o
);
    logic [CW-1:0] busy_cls;

    always_comb begin
        busy_cls = isr_any_i ? isr_cls_i : '0;
        irq_o    = irr_any_i && (irr_cls_i > busy_cls) && (irr_cls_i > tpr_cls_i);
    end
endmodule

// File: rtl/lirq_legacy_gate.sv
module lirq_legacy_gate #(
    parameter int ID_W   = 8,
    parameter int MODE_W = 3
) (
    input  logic [ID_W-1:0]   id_i,
    input  logic              gen_en_i,
    input  logic              masked_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [MODE_W-1:0] ext_mode_i,
    output logic              accept_o
);
    logic route_ok;

    always_comb begin
        route_ok = !masked_i && (mode_i == ext_mode_i);
        accept_o = (id_i == '0) && (!gen_en_i || route_ok);
    end
endmodule

// File: rtl/lirq_ack_core.sv
module lirq_ack_core #(
    parameter int NUM_VEC = 256,
    parameter int ID_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       init_evt,
    input  logic [ID_W-1:0]            self_id,
    input  logic                       pend_valid,
    input  logic [$clog2(NUM_VEC)-1:0] pend_vec,
    input  logic                       ack_req,
    input  logic                       eoi_strobe,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_sel,
    input  logic [16:0]                wr_data,
    output logic                       ack_valid,
    output logic                       ack_none,
    output logic [$clog2(NUM_VEC)-1:0] ack_vec,
    output logic                       irq_out,
    output logic                       pic_accept
);
    import lirq_pkg::*;

    localparam int VW     = $clog2(NUM_VEC);
    localparam int CLS_LO = VW - CLS_W;
    localparam logic [NUM_VEC-1:0] ONE_HOT0 = NUM_VEC'(1);
    localparam logic [VW:0]        SPUR_RST = {1'b0, {VW{1'b1}}};

    typedef struct packed {
        logic [NUM_VEC-1:0] irr;
        logic [NUM_VEC-1:0] isr;
        logic [VW-1:0]      tpr;
        logic [VW:0]        spur;
        logic [LVT_W-1:0]   lint0;
        logic               gen;
        logic               ack_valid;
        logic               ack_none;
        logic [VW-1:0]      ack_vec;
    } state_t;

    state_t st_q, st_d;

    logic [NUM_VEC-1:0] irr_q, isr_q;
    logic [VW-1:0]      tpr_q;
    logic [VW:0]        spur_q;

    assign irr_q  = st_q.irr;
    assign isr_q  = st_q.isr;
    assign tpr_q  = st_q.tpr;
    assign spur_q = st_q.spur;

    logic          irr_any, isr_any;
    logic [VW-1:0] irr_hi, isr_hi;

    lirq_hi_find #(.W(NUM_VEC), .IW(VW)) u_irr_hi (
        .vec_i (st_q.irr),
        .any_o (irr_any),
        .idx_o (irr_hi)
    );

    lirq_hi_find #(.W(NUM_VEC), .IW(VW)) u_isr_hi (
        .vec_i (st_q.isr),
        .any_o (isr_any),
        .idx_o (isr_hi)
    );

    lirq_prio_cmp #(.CW(CLS_W)) u_prio (
        .irr_any_i (irr_any),
        .irr_cls_i (irr_hi[VW-1:CLS_LO]),
        .isr_any_i (isr_any),
        .isr_cls_i (isr_hi[VW-1:CLS_LO]),
        .tpr_cls_i (st_q.tpr[VW-1:CLS_LO]),
        .irq_o     (irq_out)
    );

    lirq_legacy_gate #(.ID_W(ID_W), .MODE_W(LVT_MODE_W)) u_legacy (
        .id_i       (self_id),
        .gen_en_i   (st_q.gen),
        .masked_i   (st_q.lint0[LVT_MASK_BIT]),
        .mode_i     (st_q.lint0[LVT_MODE_LO +: LVT_MODE_W]),
        .ext_mode_i (MODE_EXTINT),
        .accept_o   (pic_accept)
    );

    logic [NUM_VEC-1:0] irr_clr, isr_set, isr_clr, pend_set;
    logic               tpr_blocks;

    always_comb begin
        st_d           = st_q;
        st_d.ack_valid = 1'b0;
        irr_clr        = '0;
        isr_set        = '0;
        isr_clr        = '0;
        pend_set       = pend_valid ? (ONE_HOT0 << pend_vec) : '0;
        tpr_blocks     = (st_q.tpr != '0) && (irr_hi <= st_q.tpr);

        // Acknowledge: result is registered and presented next cycle.
        if (ack_req) begin
            st_d.ack_valid = 1'b1;
            if (!st_q.spur[VW] || !irr_any) begin
                st_d.ack_none = 1'b1;
                st_d.ack_vec  = '0;
            end else if (tpr_blocks) begin
                st_d.ack_none = 1'b0;
                st_d.ack_vec  = st_q.spur[VW-1:0];
            end else begin
                st_d.ack_none = 1'b0;
                st_d.ack_vec  = irr_hi;
                irr_clr       = ONE_HOT0 << irr_hi;
                isr_set       = ONE_HOT0 << irr_hi;
            end
        end

        // End of interrupt retires the highest in-service vector.
        if (eoi_strobe && isr_any) begin
            isr_clr = ONE_HOT0 << isr_hi;
        end

        // A fresh request and a new service entry win over same-cycle clears.
        st_d.irr = (st_q.irr & ~irr_clr) | pend_set;
        st_d.isr = (st_q.isr & ~isr_clr) | isr_set;

        if (wr_en) begin
            unique case (lirq_sel_e'(wr_sel))
                SEL_TPR:   st_d.tpr   = wr_data[VW-1:0];
                SEL_SPUR:  st_d.spur  = wr_data[VW:0];
                SEL_LINT0: st_d.lint0 = wr_data;
                SEL_GEN:   st_d.gen   = wr_data[0];
                default:   st_d.gen   = st_q.gen;
            endcase
        end

        // INIT overrides every other update except the global enable.
        if (init_evt) begin
            st_d.irr   = '0;
            st_d.isr   = '0;
            st_d.tpr   = '0;
            st_d.spur  = SPUR_RST;
            st_d.lint0 = LVT_MASKED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.irr       <= '0;
            st_q.isr       <= '0;
            st_q.tpr       <= '0;
            st_q.spur      <= SPUR_RST;
            st_q.lint0     <= LINT0_RST;
            st_q.gen       <= 1'b1;
            st_q.ack_valid <= 1'b0;
            st_q.ack_none  <= 1'b1;
            st_q.ack_vec   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_valid = st_q.ack_valid;
    assign ack_none  = st_q.ack_none;
    assign ack_vec   = st_q.ack_vec;

endmodule

// File: rtl/lirq_ack_chk.sv
module lirq_ack_chk #(
    parameter int NUM_VEC = 256,
    parameter int VW      = $clog2(NUM_VEC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               init_evt,
    input logic               ack_req,
    input logic               eoi_strobe,
    input logic               ack_valid,
    input logic               ack_none,
    input logic [VW-1:0]      ack_vec,
    input logic               irq_out,
    input logic [NUM_VEC-1:0] irr_q,
    input logic [NUM_VEC-1:0] isr_q,
    input logic [VW-1:0]      tpr_q,
    input logic [VW:0]        spur_q
);
    // R3
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_valid);

    // R3
    ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_req |=> !ack_valid);

    // R4
    ack_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !spur_q[VW]) |=> ack_none);

    // R7
    ack_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && spur_q[VW] && tpr_q == '0 && irr_q != '0 && !init_evt)
        |=> (!ack_none && isr_q[ack_vec]));

    // R8
    eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_strobe && !ack_req && !init_evt && isr_q != '0)
        |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));

    // R10
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_evt |=> (irr_q == '0 && isr_q == '0 && tpr_q == '0 && !spur_q[VW]));

    // R9
    irq_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (irr_q != '0));
endmodule

bind lirq_ack_core lirq_ack_chk #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_evt   (init_evt),
    .ack_req    (ack_req),
    .eoi_strobe (eoi_strobe),
    .ack_valid  (ack_valid),
    .ack_none   (ack_none),
    .ack_vec    (ack_vec),
    .irq_out    (irq_out),
    .irr_q      (irr_q),
    .isr_q      (isr_q),
    .tpr_q      (tpr_q),
    .spur_q     (spur_q)
);

// File: tb/lirq_ack_core_test.sv
`timescale 1ns/1ps
module lirq_ack_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_evt = 1'b0;
    logic [7:0]  self_id = 8'd0;
    logic        pend_valid = 1'b0;
    logic [7:0]  pend_vec = 8'd0;
    logic        ack_req = 1'b0;
    logic        eoi_strobe = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [16:0] wr_data = 17'd0;
    logic        ack_valid, ack_none, irq_out, pic_accept;
    logic [7:0]  ack_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    lirq_ack_core uut (
        .clk(clk), .rst_n(rst_n), .init_evt(init_evt), .self_id(self_id),
        .pend_valid(pend_valid), .pend_vec(pend_vec), .ack_req(ack_req),
        .eoi_strobe(eoi_strobe), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ack_valid(ack_valid), .ack_none(ack_none), .ack_vec(ack_vec),
        .irq_out(irq_out), .pic_accept(pic_accept)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [16:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pend(input int v);
        @(negedge clk); pend_valid = 1'b1; pend_vec = 8'(v);
        @(negedge clk); pend_valid = 1'b0;
    endtask

    task automatic eoi();
        @(negedge clk); eoi_strobe = 1'b1;
        @(negedge clk); eoi_strobe = 1'b0;
    endtask

    task automatic pulse_init();
        @(negedge clk); init_evt = 1'b1;
        @(negedge clk); init_evt = 1'b0;
    endtask

    // exp_none=1 expects no interrupt; otherwise expects vector exp_vec.
    task automatic ack_expect(input bit exp_none, input int exp_vec, input string tag);
        @(negedge clk); ack_req = 1'b1;
        @(negedge clk); ack_req = 1'b0;
        check(ack_valid === 1'b1, "R3 ack_valid", int'(ack_valid), 1);
        if (exp_none)
            check(ack_none === 1'b1, tag, int'(ack_none), 1);
        else
            check(ack_none === 1'b0 && ack_vec == 8'(exp_vec), tag,
                  ack_none ? -1 : int'(ack_vec), exp_vec);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(irq_out === 1'b0, "R1 irq_out after reset", int'(irq_out), 0);
        check(pic_accept === 1'b1, "R1 LINT0 0x700 and enable give pic_accept", int'(pic_accept), 1);
        check(ack_valid === 1'b0, "R3 ack_valid idle", int'(ack_valid), 0);
        ack_expect(1'b1, 0, "R1 spurious enable clear after reset");

        // R4 disabled acknowledge keeps the request
        pend(8'h80);
        ack_expect(1'b1, 0, "R4 disabled ack returns none");
        @(negedge clk);
        check(ack_valid === 1'b0, "R3 ack_valid single cycle", int'(ack_valid), 0);
        wr(2'd1, 17'h1F0);
        ack_expect(1'b0, 8'h80, "R4 request kept while disabled");
        eoi();

        // R2 R7 R9 sweep over all vectors
        for (int v = 0; v < 256; v++) begin
            pend(v);
            check(irq_out === ((v >> 4) > 0), "R9 sweep irq_out", int'(irq_out), int'((v >> 4) > 0));
            ack_expect(1'b0, v, "R7 sweep ack vector");
            eoi();
        end
        ack_expect(1'b1, 0, "R5 empty after sweep");

        // R5 highest first
        pend(8'h20); pend(8'h90); pend(8'h55);
        ack_expect(1'b0, 8'h90, "R5 highest first");
        ack_expect(1'b0, 8'h55, "R5 second highest");
        ack_expect(1'b0, 8'h20, "R5 lowest last");
        eoi(); eoi(); eoi();
        ack_expect(1'b1, 0, "R5 empty returns none");

        // R6 task priority blocks
        wr(2'd0, 17'h040);
        pend(8'h40);
        ack_expect(1'b0, 8'hF0, "R6 equal to tpr gives spurious");
        ack_expect(1'b0, 8'hF0, "R6 request kept after spurious");
        pend(8'h41);
        ack_expect(1'b0, 8'h41, "R7 above tpr delivered");
        eoi();
        wr(2'd0, 17'h000);
        ack_expect(1'b0, 8'h40, "R6 blocked request still pending");
        eoi();

        // R9 class comparisons
        wr(2'd0, 17'h030);
        pend(8'h35);
        check(irq_out === 1'b0, "R9 class equals tpr class", int'(irq_out), 0);
        wr(2'd0, 17'h020);
        check(irq_out === 1'b1, "R9 class above tpr class", int'(irq_out), 1);
        wr(2'd0, 17'h000);
        ack_expect(1'b0, 8'h35, "R7 class test ack");
        pend(8'h3A);
        check(irq_out === 1'b0, "R9 class equals in-service class", int'(irq_out), 0);
        pend(8'h65);
        check(irq_out === 1'b1, "R9 class above in-service class", int'(irq_out), 1);
        ack_expect(1'b0, 8'h65, "R7 class test ack 2");
        ack_expect(1'b0, 8'h3A, "R7 class test ack 3");
        eoi(); eoi(); eoi();
        ack_expect(1'b1, 0, "R8 all retired");

        // R8 end of interrupt retires highest
        pend(8'h30); ack_expect(1'b0, 8'h30, "R7 eoi setup 1");
        pend(8'h60); ack_expect(1'b0, 8'h60, "R7 eoi setup 2");
        pend(8'h45);
        check(irq_out === 1'b0, "R9 pending below in-service", int'(irq_out), 0);
        eoi();
        check(irq_out === 1'b1, "R8 highest in-service retired", int'(irq_out), 1);
        eoi();
        eoi();
        check(irq_out === 1'b1, "R8 eoi on empty set no effect", int'(irq_out), 1);
        ack_expect(1'b0, 8'h45, "R8 empty eoi left request");
        eoi();

        // R10 INIT
        wr(2'd0, 17'h050);
        pend(8'h70);
        ack_expect(1'b0, 8'h70, "R10 setup ack");
        pend(8'h22);
        pulse_init();
        check(irq_out === 1'b0, "R10 irq low after init", int'(irq_out), 0);
        check(pic_accept === 1'b0, "R10 LINT0 masked after init", int'(pic_accept), 0);
        ack_expect(1'b1, 0, "R10 spurious disabled after init");
        wr(2'd1, 17'h1F0);
        ack_expect(1'b1, 0, "R10 pending cleared by init");
        pend(8'h12);
        check(irq_out === 1'b1, "R10 tpr and in-service cleared", int'(irq_out), 1);
        ack_expect(1'b0, 8'h12, "R10 ack after init");
        eoi();

        // R12 init overrides a same-cycle write
        @(negedge clk); init_evt = 1'b1; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 17'h080;
        @(negedge clk); init_evt = 1'b0; wr_en = 1'b0;
        wr(2'd1, 17'h1F0);
        pend(8'h13);
        ack_expect(1'b0, 8'h13, "R12 init beats tpr write");
        eoi();

        // R11 legacy acceptance sweep
        for (int idn = 0; idn < 3; idn++) begin
            for (int g = 0; g < 2; g++) begin
                for (int m = 0; m < 2; m++) begin
                    for (int md = 0; md < 8; md++) begin
                        logic [7:0] idv;
                        bit expv;
                        idv = (idn == 0) ? 8'd0 : (idn == 1) ? 8'd1 : 8'h80;
                        wr(2'd3, 17'(g));
                        wr(2'd2, {1'(m), 5'd0, 3'(md), 8'h00});
                        self_id = idv;
                        @(negedge clk);
                        expv = (idv == 8'd0) && ((g == 0) || (m == 0 && md == 7));
                        check(pic_accept === expv, "R11 legacy acceptance", int'(pic_accept), int'(expv));
                    end
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule